// File: doc/BRIEF.md
# Peripheral clock-gate and soft-reset controller

This block keeps, for up to a few dozen peripherals grouped into 32-bit banks, one clock-enable bit and one soft-reset bit each. It drives them out as per-peripheral clock-enable and reset lines. Which peripherals exist is fixed at build time by a presence mask parameter. Bits of absent peripherals never hold a 1. The block also gives a registered per-peripheral ready flag. A peripheral is ready when it exists, its clock is enabled and it is not held in soft reset.

Software changes the bits in one of two ways. It can write a whole bank word through a small register port, or it can issue a single-bit set or clear command that names one peripheral by identifier. Both kinds of change are honoured only in cycles where the protection-unlock input is high. All changes pass through one write path, so only one of them can take effect in a given cycle. A peripheral whose clock-enable line is low is meant to be gated off and to ignore its own bus accesses. The clock-gating cells sit outside this block.

Top module: `pcg_ctrl`

## Requirements
- R1: While `rst_n` is low at a rising clock edge, every bit of `pclk_en`, `prst` and `ready` becomes 0, so all peripherals start disabled.
- R2: A command identifier `cmd_id` carries the bank index in its low `BANK_IDX_W` bits and the bit position within the bank in the bits above. Peripheral number = bank*32 + bit.
- R3: `reg_addr` has the register kind in its top two bits and the bank index in the low bits. The kinds are: 0 presence (read-only), 1 clock-enable, 2 soft-reset, 3 ready. `reg_rdata` shows the addressed word in the same cycle. A write to kind 0 or kind 3 changes nothing.
- R4: `ready[n]` equals presence AND clock-enable AND NOT soft-reset, as sampled one clock earlier. It lags any enable or reset change by exactly one cycle.
- R5: A word write or a command in a cycle where `unlock` is low has no effect on any bit.
- R6: Bits of peripherals whose presence bit is 0 ignore all writes and commands, and they always read and drive 0.
- R7: `cmd_op` encodings are 0 enable-set, 1 enable-clear, 2 reset-set and 3 reset-clear. A command changes only the one addressed bit and leaves all others as they were.
- R8: When `reg_wr` and `cmd_valid` are both high in one cycle, the word write takes effect and the command is dropped.
- R9: `pclk_en[n]` and `prst[n]` follow the stored enable and soft-reset bits one cycle after the accepted change. A pulse of the soft-reset bit shows up as a pulse on `prst`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| unlock | input | 1 | Protection unlock; writes count only while high |
| reg_wr | input | 1 | Whole-word register write strobe |
| reg_addr | input | ADDR_W | Register kind (top two bits) and bank index |
| reg_wdata | input | BANK_W | Write data for a whole bank word |
| reg_rdata | output | BANK_W | Read data for the addressed word |
| cmd_valid | input | 1 | Single-bit command strobe |
| cmd_op | input | 2 | Command operation code |
| cmd_id | input | ID_W | Peripheral identifier: bit position above bank index |
| pclk_en | output | NPER | Per-peripheral clock enable |
| prst | output | NPER | Per-peripheral soft-reset line |
| ready | output | NPER | Per-peripheral registered ready flag |

## Verification
Every one of the 64 identifiers is driven through set and clear commands in order. This shows that the bank and bit fields are decoded separately and land on the right output, and that absent slots stay dark. The same sweep run with `unlock` low separates the lock from the decode. Soft reset is set on a sparse stride of peripherals while they are enabled, which separates the ready term that uses enable from the one that uses reset. A single release is then timed to the cycle to show the one-cycle ready lag. Whole-word writes with alternating patterns, writes to the read-only kinds, and a word write that collides with a command cover the address map, masking and the write priority.

// File: rtl/pcg_pkg.sv
`timescale 1ns/1ps
// Shared encodings for the peripheral clock-gate controller.
// Assumes: register kind occupies the two top address bits.
package pcg_pkg;
    typedef enum logic [1:0] {
        OP_EN_SET  = 2'd0,
        OP_EN_CLR  = 2'd1,
        OP_RST_SET = 2'd2,
        OP_RST_CLR = 2'd3
    } pcg_op_e;

    typedef enum logic [1:0] {
        RK_PRES  = 2'd0,
        RK_EN    = 2'd1,
        RK_RST   = 2'd2,
        RK_READY = 2'd3
    } pcg_kind_e;
endpackage

// File: rtl/pcg_id_decode.sv
`timescale 1ns/1ps
// Splits a peripheral identifier into a one-hot bank select and a bit mask.
// Assumes: bank index in the low field, bit position in the field above it.
// An out-of-range bank index selects no bank.
module pcg_id_decode #(
    parameter int NUM_BANKS  = 2,
    parameter int BANK_W     = 32,
    parameter int BANK_IDX_W = 1,
    parameter int BIT_IDX_W  = 5
) (
    input  logic [BANK_IDX_W+BIT_IDX_W-1:0] id,
    output logic [NUM_BANKS-1:0]            bank_sel,
    output logic [BANK_W-1:0]               bit_mask
);
    logic [BANK_IDX_W-1:0] bank_f;
    logic [BIT_IDX_W-1:0]  bit_f;

    assign bank_f = id[BANK_IDX_W-1:0];
    assign bit_f  = id[BANK_IDX_W+BIT_IDX_W-1:BANK_IDX_W];

    // One select line per bank, compared against the low field.
    generate
        for (genvar b = 0; b < NUM_BANKS; b++) begin : g_sel
            assign bank_sel[b] = (bank_f == BANK_IDX_W'(b));
        end
    endgenerate

    // Single-bit mask from the upper field.
    always_comb begin
        bit_mask = '0;
        bit_mask[bit_f] = 1'b1;
    end
endmodule

// File: rtl/pcg_bank.sv
`timescale 1ns/1ps
// One bank of enable, soft-reset and ready state.
// Assumes: word write strobes and the command hit are already qualified by
// the unlock flag and are never high together (the top enforces priority).
module pcg_bank
    import pcg_pkg::*;
#(
    parameter int              W    = 32,
    parameter logic [W-1:0]    PRES = '1
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          word_en_wr,
    input  logic          word_rst_wr,
    input  logic [W-1:0]  wdata,
    input  logic          cmd_hit,
    input  pcg_op_e       cmd_op,
    input  logic [W-1:0]  cmd_mask,
    output logic [W-1:0]  en_q,
    output logic [W-1:0]  rst_q,
    output logic [W-1:0]  rdy_q
);
    logic [W-1:0] en_nxt, rst_nxt;

    // Next enable word: word write, else single-bit read-modify-write.
    always_comb begin
        en_nxt = en_q;
        if (word_en_wr)
            en_nxt = wdata;
        else if (cmd_hit && cmd_op == OP_EN_SET)
            en_nxt = en_q | cmd_mask;
        else if (cmd_hit && cmd_op == OP_EN_CLR)
            en_nxt = en_q & ~cmd_mask;
    end

    // Next soft-reset word: same structure as the enable path.
    always_comb begin
        rst_nxt = rst_q;
        if (word_rst_wr)
            rst_nxt = wdata;
        else if (cmd_hit && cmd_op == OP_RST_SET)
            rst_nxt = rst_q | cmd_mask;
        else if (cmd_hit && cmd_op == OP_RST_CLR)
            rst_nxt = rst_q & ~cmd_mask;
    end

    // State registers; absent slots are masked to zero on every load.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            en_q  <= '0;
            rst_q <= '0;
            rdy_q <= '0;
        end else begin
            en_q  <= en_nxt & PRES;
            rst_q <= rst_nxt & PRES;
            rdy_q <= en_q & ~rst_q & PRES;
        end
    end
endmodule

// File: rtl/pcg_ctrl.sv
`timescale 1ns/1ps
// Peripheral clock-gate and soft-reset controller (top).
// Holds per-peripheral enable and soft-reset bits in banks, accepts
// whole-word writes and single-bit commands while unlock is high, and
// drives clock-enable, reset and a registered ready flag per peripheral.
// Assumes: a word write in the same cycle as a command wins.
module pcg_ctrl
    import pcg_pkg::*;
#(
    parameter int NUM_BANKS = 2,
    parameter int BANK_W    = 32,
    parameter logic [NUM_BANKS*BANK_W-1:0] PRESENT_MASK = 64'hFFFF_0FFF_F7FF_FF3F,
    localparam int NPER       = NUM_BANKS * BANK_W,
    localparam int BANK_IDX_W = (NUM_BANKS > 1) ? $clog2(NUM_BANKS) : 1,
    localparam int BIT_IDX_W  = $clog2(BANK_W),
    localparam int ID_W       = BANK_IDX_W + BIT_IDX_W,
    localparam int ADDR_W     = BANK_IDX_W + 2
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              unlock,
    input  logic              reg_wr,
    input  logic [ADDR_W-1:0] reg_addr,
    input  logic [BANK_W-1:0] reg_wdata,
    output logic [BANK_W-1:0] reg_rdata,
    input  logic              cmd_valid,
    input  logic [1:0]        cmd_op,
    input  logic [ID_W-1:0]   cmd_id,
    output logic [NPER-1:0]   pclk_en,
    output logic [NPER-1:0]   prst,
    output logic [NPER-1:0]   ready
);
    pcg_kind_e             kind;
    logic [BANK_IDX_W-1:0] rbank;
    logic                  wr_ok, cmd_ok;
    logic [NUM_BANKS-1:0]  cmd_bank_sel;
    logic [BANK_W-1:0]     cmd_mask;

    assign kind   = pcg_kind_e'(reg_addr[ADDR_W-1 -: 2]);
    assign rbank  = reg_addr[BANK_IDX_W-1:0];
    assign wr_ok  = reg_wr && unlock;
    assign cmd_ok = cmd_valid && unlock && !reg_wr;

    pcg_id_decode #(
        .NUM_BANKS (NUM_BANKS),
        .BANK_W    (BANK_W),
        .BANK_IDX_W(BANK_IDX_W),
        .BIT_IDX_W (BIT_IDX_W)
    ) u_dec (
        .id      (cmd_id),
        .bank_sel(cmd_bank_sel),
        .bit_mask(cmd_mask)
    );

    // One bank instance per 32-bit slice of the peripheral set.
    generate
        for (genvar b = 0; b < NUM_BANKS; b++) begin : g_bank
            logic hit_word;
            assign hit_word = wr_ok && (rbank == BANK_IDX_W'(b));

            pcg_bank #(
                .W   (BANK_W),
                .PRES(PRESENT_MASK[b*BANK_W +: BANK_W])
            ) u_bank (
                .clk        (clk),
                .rst_n      (rst_n),
                .word_en_wr (hit_word && kind == RK_EN),
                .word_rst_wr(hit_word && kind == RK_RST),
                .wdata      (reg_wdata),
                .cmd_hit    (cmd_ok && cmd_bank_sel[b]),
                .cmd_op     (pcg_op_e'(cmd_op)),
                .cmd_mask   (cmd_mask),
                .en_q       (pclk_en[b*BANK_W +: BANK_W]),
                .rst_q      (prst[b*BANK_W +: BANK_W]),
                .rdy_q      (ready[b*BANK_W +: BANK_W])
            );
        end
    endgenerate

    // Read mux: selects the addressed bank word of the addressed kind.
    always_comb begin
        reg_rdata = '0;
        for (int b = 0; b < NUM_BANKS; b++) begin
            if (rbank == BANK_IDX_W'(b)) begin
                case (kind)
                    RK_PRES:  reg_rdata = PRESENT_MASK[b*BANK_W +: BANK_W];
                    RK_EN:    reg_rdata = pclk_en[b*BANK_W +: BANK_W];
                    RK_RST:   reg_rdata = prst[b*BANK_W +: BANK_W];
                    default:  reg_rdata = ready[b*BANK_W +: BANK_W];
                endcase
            end
        end
    end
endmodule

// File: rtl/pcg_ctrl_chk.sv
`timescale 1ns/1ps
// Temporal checks on the controller's outputs, bound into pcg_ctrl.
// Assumes: same presence mask as the bound instance.
module pcg_ctrl_chk #(
    parameter int NPER = 64,
    parameter logic [NPER-1:0] PRESENT_MASK = '1
) (
    input logic            clk,
    input logic            rst_n,
    input logic            unlock,
    input logic            reg_wr,
    input logic            cmd_valid,
    input logic [NPER-1:0] pclk_en,
    input logic [NPER-1:0] prst,
    input logic [NPER-1:0] ready
);
    // R1: a reset edge clears every output line.
    p_reset_clear_r1: assert property (@(posedge clk)
        !rst_n |=> (pclk_en == '0 && prst == '0 && ready == '0));

    // R4: ready is last cycle's enable and not reset.
    p_ready_lag_r4: assert property (@(posedge clk) disable iff (!rst_n)
        1'b1 |=> ready == ($past(pclk_en) & ~$past(prst)));

    // R5: nothing changes after a locked cycle.
    p_locked_hold_r5: assert property (@(posedge clk) disable iff (!rst_n)
        !unlock |=> ($stable(pclk_en) && $stable(prst)));

    // R6: absent slots never drive a 1.
    p_absent_dark_r6: assert property (@(posedge clk) disable iff (!rst_n)
        ((pclk_en | prst | ready) & ~PRESENT_MASK) == '0);

    // R7: with no request, state holds.
    p_idle_hold_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (!reg_wr && !cmd_valid) |=> ($stable(pclk_en) && $stable(prst)));
endmodule

bind pcg_ctrl pcg_ctrl_chk #(
    .NPER(NPER),
    .PRESENT_MASK(PRESENT_MASK)
) u_chk (
    .clk(clk), .rst_n(rst_n), .unlock(unlock), .reg_wr(reg_wr),
    .cmd_valid(cmd_valid), .pclk_en(pclk_en), .prst(prst), .ready(ready)
);

// File: tb/sim_pcg_ctrl.sv
`timescale 1ns/1ps
module sim_pcg_ctrl;
    localparam logic [63:0] PM = 64'hFFFF_0FFF_F7FF_FF3F;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        unlock = 1'b0;
    logic        reg_wr = 1'b0;
    logic [2:0]  reg_addr = '0;
    logic [31:0] reg_wdata = '0;
    logic [31:0] reg_rdata;
    logic        cmd_valid = 1'b0;
    logic [1:0]  cmd_op = '0;
    logic [5:0]  cmd_id = '0;
    logic [63:0] pclk_en, prst, ready;

    logic [63:0] m_en = '0, m_rst = '0;
    int n_vec = 0, n_bad = 0;
    bit finished = 0;

    always #10 clk = ~clk;

    pcg_ctrl #(.NUM_BANKS(2), .BANK_W(32), .PRESENT_MASK(PM)) u0 (
        .clk(clk), .rst_n(rst_n), .unlock(unlock), .reg_wr(reg_wr),
        .reg_addr(reg_addr), .reg_wdata(reg_wdata), .reg_rdata(reg_rdata),
        .cmd_valid(cmd_valid), .cmd_op(cmd_op), .cmd_id(cmd_id),
        .pclk_en(pclk_en), .prst(prst), .ready(ready)
    );

    task automatic chk(string tag, logic [63:0] act, logic [63:0] exp);
        n_vec++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s act=%h exp=%h", tag, act, exp);
        end
    endtask

    // Apply one command for one cycle, then one idle cycle so ready settles.
    task automatic do_cmd(logic [1:0] op, int n, logic unl);
        int bank = n / 32;
        int bitp = n % 32;
        @(negedge clk);
        cmd_valid = 1'b1; cmd_op = op; cmd_id = {bitp[4:0], bank[0]}; unlock = unl;
        @(negedge clk);
        cmd_valid = 1'b0; unlock = 1'b0;
        if (unl) begin
            case (op)
                2'd0: m_en[n]  = 1'b1;
                2'd1: m_en[n]  = 1'b0;
                2'd2: m_rst[n] = 1'b1;
                default: m_rst[n] = 1'b0;
            endcase
        end
        @(negedge clk);
    endtask

    task automatic check_all(string tag);
        chk({tag, " pclk_en"}, pclk_en, m_en & PM);
        chk({tag, " prst"}, prst, m_rst & PM);
        chk({tag, " ready"}, ready, m_en & ~m_rst & PM);
    endtask

    task automatic wr_word(logic [1:0] kind, int bank, logic [31:0] d, logic unl);
        @(negedge clk);
        reg_wr = 1'b1; reg_addr = {kind, bank[0]}; reg_wdata = d; unlock = unl;
        @(negedge clk);
        reg_wr = 1'b0; unlock = 1'b0;
        if (unl && kind == 2'd1) m_en[bank*32 +: 32] = d;
        if (unl && kind == 2'd2) m_rst[bank*32 +: 32] = d;
        @(negedge clk);
    endtask

    task automatic rd_word(logic [1:0] kind, int bank, output logic [31:0] d);
        @(negedge clk);
        reg_addr = {kind, bank[0]};
        #1 d = reg_rdata;
    endtask

    initial begin
        #(20 * 200000);
        if (!finished) begin
            n_vec++; n_bad++;
            $display("FAIL watchdog act=hung exp=done");
            $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
            $finish;
        end
    end

    initial begin
        logic [31:0] rd;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        check_all("R1 reset state");

        // R5: locked commands over every identifier change nothing.
        for (int n = 0; n < 64; n++) begin
            do_cmd(2'd0, n, 1'b0);
            chk("R5 locked enable-set", pclk_en, 64'h0);
        end

        // R2/R6/R7: enable every identifier in turn; absent ones stay 0.
        for (int n = 0; n < 64; n++) begin
            do_cmd(2'd0, n, 1'b1);
            check_all("R2 R6 R7 enable sweep");
        end

        // R4/R9: soft reset on every third peripheral.
        for (int n = 0; n < 64; n += 3) begin
            do_cmd(2'd2, n, 1'b1);
            check_all("R4 R9 reset stride");
        end

        // R4: one-cycle ready lag on release of peripheral 3.
        @(negedge clk);
        cmd_valid = 1'b1; cmd_op = 2'd3; cmd_id = {5'd3, 1'b0}; unlock = 1'b1;
        @(negedge clk);
        cmd_valid = 1'b0; unlock = 1'b0; m_rst[3] = 1'b0;
        chk("R9 prst released", {63'h0, prst[3]}, 64'h0);
        chk("R4 ready still low", {63'h0, ready[3]}, 64'h0);
        @(negedge clk);
        chk("R4 ready one cycle later", {63'h0, ready[3]}, 64'h1);

        // R7: clear resets everywhere, then disable even peripherals.
        for (int n = 0; n < 64; n += 3) do_cmd(2'd3, n, 1'b1);
        check_all("R7 reset-clear");
        for (int n = 0; n < 64; n += 2) do_cmd(2'd1, n, 1'b1);
        check_all("R7 enable-clear even");

        // R3/R6: word writes with patterns, read back through the port.
        for (int b = 0; b < 2; b++) begin
            wr_word(2'd1, b, 32'hAAAA_5555, 1'b1);
            rd_word(2'd1, b, rd);
            chk("R3 R6 enable word readback", {32'h0, rd}, {32'h0, 32'hAAAA_5555 & PM[b*32 +: 32]});
            wr_word(2'd2, b, 32'h0F0F_F0F0, 1'b1);
            rd_word(2'd2, b, rd);
            chk("R3 R6 reset word readback", {32'h0, rd}, {32'h0, 32'h0F0F_F0F0 & PM[b*32 +: 32]});
            check_all("R9 word write outputs");
            rd_word(2'd3, b, rd);
            chk("R3 ready word readback", {32'h0, rd}, {32'h0, (m_en & ~m_rst & PM) >> (b*32)} & 64'hFFFF_FFFF);
            wr_word(2'd0, b, 32'h0, 1'b1);
            rd_word(2'd0, b, rd);
            chk("R3 presence read-only", {32'h0, rd}, {32'h0, PM[b*32 +: 32]});
            wr_word(2'd3, b, 32'h0, 1'b1);
            check_all("R3 ready kind write ignored");
            wr_word(2'd1, b, 32'hFFFF_FFFF, 1'b0);
            check_all("R5 locked word write");
        end

        // R8: word write to bank 0 collides with a command to bank 1 bit 5.
        do_cmd(2'd1, 37, 1'b1);
        @(negedge clk);
        reg_wr = 1'b1; reg_addr = {2'd1, 1'b0}; reg_wdata = 32'h0; unlock = 1'b1;
        cmd_valid = 1'b1; cmd_op = 2'd0; cmd_id = {5'd5, 1'b1};
        @(negedge clk);
        reg_wr = 1'b0; cmd_valid = 1'b0; unlock = 1'b0;
        m_en[31:0] = 32'h0;
        @(negedge clk);
        check_all("R8 word write wins");

        // R1: reset in mid-run clears everything.
        @(negedge clk); rst_n = 1'b0;
        @(negedge clk); rst_n = 1'b1;
        m_en = '0; m_rst = '0;
        check_all("R1 reset again");

        finished = 1;
        $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
        $finish;
    end
endmodule